// File: doc/BRIEF.md
# Command Status State Machine

This block owns the status word and the command lifecycle of the currently active locality in a command/response security-module host interface. Software controls it with single-bit writes to the status word: one bit asks for a fresh command slot, one launches execution of a fully received command, and one replays the response from its first byte. A data path next to it reports each command byte pushed into the FIFO (with a flag on the final byte) and each response byte pulled out. An external engine performs the actual command and signals completion with a strobe that carries the response length.

The machine moves through five states: Init, Ready, CommandReception, CommandExecution and CommandCompletion. The status word that software reads is built from the state, from the byte counters and from a self-test strap. A read from a locality that does not hold the interface returns all ones. Three one-cycle pulses leave the block: one that starts execution, and two that an interrupt block can use (entry to Ready, response available).

Top module: `cmd_status_engine`

## Requirements
- R1: Reset enters Init. In Init the status word reads 0x0000_0084 with the strap high: the layout is bit 1 responseRetry (reads 0), bit 2 selfTestDone, bit 3 expect, bit 4 dataAvail, bit 5 go (reads 0), bit 6 commandReady, bit 7 stsValid, bits 23:8 burst count, all other bits 0.
- R2: A status write is ignored unless `locValid` is high, `wrLoc` equals `activeLoc`, and `wrData` has exactly one bit set.
- R3: A read with `locValid` low or `rdLoc` different from `activeLoc` returns 0xFFFF_FFFF.
- R4: An accepted write of bit 6 (commandReady) moves the machine to Ready from any state and clears the byte counters. Ready reads commandReady 1. `evtCmdReady` pulses for one cycle, the cycle after the write, only when the machine was not already in Ready.
- R5: A `fifoWr` in Ready moves the machine to CommandReception and counts the byte; further bytes are counted in CommandReception up to the FIFO depth. expect reads 1 after a byte without `fifoLast` and 0 after a byte with `fifoLast`. `fifoWr` in Init, CommandExecution or CommandCompletion has no effect.
- R6: An accepted write of bit 5 (go) is honoured only in CommandReception with expect 0: the machine enters CommandExecution and `execStart` pulses for one cycle. In every other case it has no effect. In CommandExecution stsValid, expect, dataAvail and the burst count read 0.
- R7: `execDone` in CommandExecution moves the machine to CommandCompletion, latches `rspLen` as the response length and pulses `evtDataAvail` for one cycle. `execDone` in any other state has no effect.
- R8: In CommandCompletion each `fifoRd` removes one response byte; dataAvail reads 1 while bytes remain and 0 once none remain; reads beyond the end change nothing.
- R9: An accepted write of bit 1 (responseRetry) in CommandCompletion restores the remaining count to the full latched length; in any other state it has no effect.
- R10: The burst count reads min(FIFO_DEPTH minus bytes received, BURST_CAP) in Ready and CommandReception, min(bytes remaining, BURST_CAP) in CommandCompletion, and 0 in Init and CommandExecution (FIFO_DEPTH 128, BURST_CAP 64 by default).
- R11: selfTestDone (bit 2) follows the `selfTestStrap` input in every state of an active-locality read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| selfTestStrap | input | 1 | Level shown as selfTestDone |
| locValid | input | 1 | A locality currently holds the interface |
| activeLoc | input | LOC_W | Number of the active locality |
| wrEn | input | 1 | Status write strobe |
| wrLoc | input | LOC_W | Locality issuing the write |
| wrData | input | 32 | Write value |
| rdLoc | input | LOC_W | Locality issuing the read |
| rdData | output | 32 | Status word seen by `rdLoc` |
| fifoWr | input | 1 | One command byte entered the FIFO |
| fifoLast | input | 1 | Qualifies `fifoWr` as the final command byte |
| fifoRd | input | 1 | One response byte left the FIFO |
| execDone | input | 1 | Command engine finished |
| rspLen | input | RSP_W | Response length, valid with `execDone` |
| execStart | output | 1 | One-cycle pulse starting the command engine |
| evtCmdReady | output | 1 | One-cycle pulse on entry to Ready |
| evtDataAvail | output | 1 | One-cycle pulse when a response becomes available |

## Verification
The bench goes after the write filter with a correct bit from the wrong locality, a two-bit write from the right locality and a write with no locality active; a filter that checked only one condition would leave Init or launch execution. It tries go in Ready and while expect is still 1, and responseRetry outside CommandCompletion, where a loose gate would start the engine early or corrupt the counters. It drives the burst count through the cap, below the cap and to zero at a full FIFO, and reads past the end of a response, where an off-by-one or a missing saturation would show a wrong field or a wrapped count. Abort by commandReady from CommandCompletion and CommandReception, and a repeated commandReady in Ready that must not pulse again, cover the event logic.

// File: rtl/cse_pkg.sv
package cse_pkg;

  typedef enum logic [2:0] {
    ST_INIT  = 3'd0,
    ST_READY = 3'd1,
    ST_RECV  = 3'd2,
    ST_EXEC  = 3'd3,
    ST_COMPL = 3'd4
  } cseState_t;

  // Strobes from the control FSM to the counter datapath.
  typedef struct packed {
    logic clearCmd;
    logic countCmdByte;
    logic loadRsp;
    logic replayRsp;
    logic consumeRsp;
  } cseStrobe_t;

  // Bit positions of the status word (software decodes these).
  localparam int BIT_RETRY    = 1;
  localparam int BIT_SELFTEST = 2;
  localparam int BIT_EXPECT   = 3;
  localparam int BIT_AVAIL    = 4;
  localparam int BIT_GO       = 5;
  localparam int BIT_CMDRDY   = 6;
  localparam int BIT_VALID    = 7;
  localparam int BURST_LSB    = 8;
  localparam int BURST_W      = 16;

endpackage

// File: rtl/cse_control.sv
module cse_control
  import cse_pkg::*;
#(
  parameter int LOC_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             locValid,
  input  logic [LOC_W-1:0] activeLoc,
  input  logic             wrEn,
  input  logic [LOC_W-1:0] wrLoc,
  input  logic [31:0]      wrData,
  input  logic             fifoWr,
  input  logic             fifoRd,
  input  logic             execDone,
  input  logic             expectFlag,
  output cseState_t        state,
  output cseStrobe_t       strobe,
  output logic             execStart,
  output logic             evtCmdReady,
  output logic             evtDataAvail
);

  logic      wrAccepted;
  logic      reqCmdRdy;
  logic      reqGo;
  logic      reqRetry;
  cseState_t stateNext;
  logic      startNext;
  logic      cmdRdyNext;
  logic      availNext;

  assign wrAccepted = wrEn && locValid && (wrLoc == activeLoc) && $onehot(wrData);
  assign reqCmdRdy  = wrAccepted && wrData[BIT_CMDRDY];
  assign reqGo      = wrAccepted && wrData[BIT_GO];
  assign reqRetry   = wrAccepted && wrData[BIT_RETRY];

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    startNext  = 1'b0;
    cmdRdyNext = 1'b0;
    availNext  = 1'b0;
    if (reqCmdRdy) begin
      stateNext       = ST_READY;
      strobe.clearCmd = 1'b1;
      cmdRdyNext      = (state != ST_READY);
    end else begin
      unique case (state)
        ST_READY: begin
          if (fifoWr) begin
            stateNext           = ST_RECV;
            strobe.countCmdByte = 1'b1;
          end
        end
        ST_RECV: begin
          if (reqGo && !expectFlag) begin
            stateNext = ST_EXEC;
            startNext = 1'b1;
          end else if (fifoWr) begin
            strobe.countCmdByte = 1'b1;
          end
        end
        ST_EXEC: begin
          if (execDone) begin
            stateNext      = ST_COMPL;
            strobe.loadRsp = 1'b1;
            availNext      = 1'b1;
          end
        end
        ST_COMPL: begin
          if (reqRetry) begin
            strobe.replayRsp = 1'b1;
          end else if (fifoRd) begin
            strobe.consumeRsp = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_INIT;
      execStart    <= 1'b0;
      evtCmdReady  <= 1'b0;
      evtDataAvail <= 1'b0;
    end else begin
      state        <= stateNext;
      execStart    <= startNext;
      evtCmdReady  <= cmdRdyNext;
      evtDataAvail <= availNext;
    end
  end

endmodule

// File: rtl/cse_datapath.sv
module cse_datapath
  import cse_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  parameter int MAX_RSP    = 4096,
  parameter int BURST_CAP  = 64,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1),
  localparam int RSP_W     = $clog2(MAX_RSP + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  cseState_t        state,
  input  cseStrobe_t       strobe,
  input  logic             fifoLast,
  input  logic [RSP_W-1:0] rspLenIn,
  input  logic             selfTestStrap,
  output logic             expectFlag,
  output logic [31:0]      statusWord
);

  logic [CNT_W-1:0]   cmdCount;
  logic [RSP_W-1:0]   rspTotal;
  logic [RSP_W-1:0]   rspLeft;
  logic [31:0]        avail;
  logic [BURST_W-1:0] burst;
  logic               cmdFull;

  assign cmdFull = (32'(cmdCount) >= 32'(FIFO_DEPTH));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdCount   <= '0;
      expectFlag <= 1'b0;
      rspTotal   <= '0;
      rspLeft    <= '0;
    end else begin
      if (strobe.clearCmd) begin
        cmdCount   <= '0;
        expectFlag <= 1'b0;
        rspLeft    <= '0;
      end
      if (strobe.countCmdByte) begin
        if (!cmdFull) cmdCount <= cmdCount + 1'b1;
        expectFlag <= !fifoLast;
      end
      if (strobe.loadRsp) begin
        rspTotal <= rspLenIn;
        rspLeft  <= rspLenIn;
      end
      if (strobe.replayRsp) rspLeft <= rspTotal;
      if (strobe.consumeRsp && (rspLeft != '0)) rspLeft <= rspLeft - 1'b1;
    end
  end

  always_comb begin
    unique case (state)
      ST_READY, ST_RECV: avail = 32'(FIFO_DEPTH) - 32'(cmdCount);
      ST_COMPL:          avail = 32'(rspLeft);
      default:           avail = 32'd0;
    endcase
    burst = (avail > 32'(BURST_CAP)) ? BURST_W'(BURST_CAP) : avail[BURST_W-1:0];
  end

  always_comb begin
    statusWord                                = '0;
    statusWord[BURST_LSB +: BURST_W]          = burst;
    statusWord[BIT_VALID]                     = (state != ST_EXEC);
    statusWord[BIT_CMDRDY]                    = (state == ST_READY);
    statusWord[BIT_AVAIL]                     = (state == ST_COMPL) && (rspLeft != '0);
    statusWord[BIT_EXPECT]                    = (state == ST_RECV) && expectFlag;
    statusWord[BIT_SELFTEST]                  = selfTestStrap;
  end

endmodule

// File: rtl/cmd_status_engine.sv
module cmd_status_engine
  import cse_pkg::*;
#(
  parameter int NUM_LOC    = 5,
  parameter int FIFO_DEPTH = 128,
  parameter int MAX_RSP    = 4096,
  parameter int BURST_CAP  = 64,
  localparam int LOC_W     = $clog2(NUM_LOC),
  localparam int RSP_W     = $clog2(MAX_RSP + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             selfTestStrap,
  input  logic             locValid,
  input  logic [LOC_W-1:0] activeLoc,
  input  logic             wrEn,
  input  logic [LOC_W-1:0] wrLoc,
  input  logic [31:0]      wrData,
  input  logic [LOC_W-1:0] rdLoc,
  output logic [31:0]      rdData,
  input  logic             fifoWr,
  input  logic             fifoLast,
  input  logic             fifoRd,
  input  logic             execDone,
  input  logic [RSP_W-1:0] rspLen,
  output logic             execStart,
  output logic             evtCmdReady,
  output logic             evtDataAvail
);

  cseState_t  state;
  cseStrobe_t strobe;
  logic       expectFlag;
  logic [31:0] statusWord;

  cse_control #(.LOC_W(LOC_W)) u_control (
    .clk          (clk),
    .rstN         (rstN),
    .locValid     (locValid),
    .activeLoc    (activeLoc),
    .wrEn         (wrEn),
    .wrLoc        (wrLoc),
    .wrData       (wrData),
    .fifoWr       (fifoWr),
    .fifoRd       (fifoRd),
    .execDone     (execDone),
    .expectFlag   (expectFlag),
    .state        (state),
    .strobe       (strobe),
    .execStart    (execStart),
    .evtCmdReady  (evtCmdReady),
    .evtDataAvail (evtDataAvail)
  );

  cse_datapath #(
    .FIFO_DEPTH (FIFO_DEPTH),
    .MAX_RSP    (MAX_RSP),
    .BURST_CAP  (BURST_CAP)
  ) u_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .state         (state),
    .strobe        (strobe),
    .fifoLast      (fifoLast),
    .rspLenIn      (rspLen),
    .selfTestStrap (selfTestStrap),
    .expectFlag    (expectFlag),
    .statusWord    (statusWord)
  );

  assign rdData = (locValid && (rdLoc == activeLoc)) ? statusWord : 32'hFFFF_FFFF;

endmodule

// File: rtl/cse_checker.sv
module cse_checker
  import cse_pkg::*;
#(
  parameter int LOC_W     = 3,
  parameter int BURST_CAP = 64
) (
  input logic             clk,
  input logic             rstN,
  input logic             locValid,
  input logic [LOC_W-1:0] activeLoc,
  input logic             wrEn,
  input logic [31:0]      wrData,
  input logic [LOC_W-1:0] rdLoc,
  input logic [31:0]      rdData,
  input logic             fifoWr,
  input logic             execDone,
  input logic             execStart,
  input logic             evtCmdReady,
  input logic             evtDataAvail,
  input cseState_t        state
);

  logic ownRead;
  assign ownRead = locValid && (rdLoc == activeLoc);

  p_foreign_read_r3: assert property (@(posedge clk) disable iff (!rstN)
    !ownRead |-> rdData == 32'hFFFF_FFFF);

  p_multibit_ignored_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !$onehot(wrData) && !fifoWr && !execDone) |=> $stable(state));

  p_init_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_INIT && !(wrEn && wrData == 32'h0000_0040)) |=> state == ST_INIT);

  p_ready_event_r4: assert property (@(posedge clk) disable iff (!rstN)
    evtCmdReady |-> (state == ST_READY && $past(state) != ST_READY));

  p_go_gate_r6: assert property (@(posedge clk) disable iff (!rstN)
    execStart |-> (state == ST_EXEC && $past(state) == ST_RECV));

  p_exec_invalid_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_EXEC && ownRead) |-> rdData[BIT_VALID] == 1'b0);

  p_done_event_r7: assert property (@(posedge clk) disable iff (!rstN)
    evtDataAvail |-> (state == ST_COMPL && $past(state) == ST_EXEC));

  p_burst_cap_r10: assert property (@(posedge clk) disable iff (!rstN)
    ownRead |-> 32'(rdData[BURST_LSB +: BURST_W]) <= 32'(BURST_CAP));

  p_avail_only_compl_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ownRead && rdData[BIT_AVAIL]) |-> state == ST_COMPL);

endmodule

bind cmd_status_engine cse_checker #(.LOC_W(LOC_W), .BURST_CAP(BURST_CAP)) u_cseChecker (
  .clk          (clk),
  .rstN         (rstN),
  .locValid     (locValid),
  .activeLoc    (activeLoc),
  .wrEn         (wrEn),
  .wrData       (wrData),
  .rdLoc        (rdLoc),
  .rdData       (rdData),
  .fifoWr       (fifoWr),
  .execDone     (execDone),
  .execStart    (execStart),
  .evtCmdReady  (evtCmdReady),
  .evtDataAvail (evtDataAvail),
  .state        (state)
);

// File: tb/test_cmd_status_engine.sv
`timescale 1ns/1ps
module test_cmd_status_engine;

  localparam int LOC_W = 3;
  localparam int RSP_W = 13;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             selfTestStrap = 1'b1;
  logic             locValid = 1'b1;
  logic [LOC_W-1:0] activeLoc = 3'd2;
  logic             wrEn = 1'b0;
  logic [LOC_W-1:0] wrLoc = 3'd2;
  logic [31:0]      wrData = '0;
  logic [LOC_W-1:0] rdLoc = 3'd2;
  logic [31:0]      rdData;
  logic             fifoWr = 1'b0;
  logic             fifoLast = 1'b0;
  logic             fifoRd = 1'b0;
  logic             execDone = 1'b0;
  logic [RSP_W-1:0] rspLen = '0;
  logic             execStart;
  logic             evtCmdReady;
  logic             evtDataAvail;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic seenStart, seenRdy, seenAvail;

  always #4 clk = ~clk;

  cmd_status_engine i_cmd_status_engine (
    .clk(clk), .rstN(rstN), .selfTestStrap(selfTestStrap), .locValid(locValid),
    .activeLoc(activeLoc), .wrEn(wrEn), .wrLoc(wrLoc), .wrData(wrData),
    .rdLoc(rdLoc), .rdData(rdData), .fifoWr(fifoWr), .fifoLast(fifoLast),
    .fifoRd(fifoRd), .execDone(execDone), .rspLen(rspLen), .execStart(execStart),
    .evtCmdReady(evtCmdReady), .evtDataAvail(evtDataAvail)
  );

  task automatic checkEq(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic readSts(string req, logic [LOC_W-1:0] loc, logic [31:0] exp);
    rdLoc = loc;
    #1;
    checkEq(req, rdData, exp);
    rdLoc = activeLoc;
  endtask

  task automatic regWrite(logic [LOC_W-1:0] loc, logic [31:0] val);
    @(negedge clk);
    wrEn = 1'b1; wrLoc = loc; wrData = val;
    @(negedge clk);
    seenStart = execStart; seenRdy = evtCmdReady;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pushBytes(int n, logic lastFlag);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      fifoWr = 1'b1;
      fifoLast = lastFlag && (i == n - 1);
      @(negedge clk);
    end
    fifoWr = 1'b0; fifoLast = 1'b0;
  endtask

  task automatic pullBytes(int n);
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      fifoRd = 1'b1;
      @(negedge clk);
    end
    fifoRd = 1'b0;
  endtask

  task automatic finishExec(logic [RSP_W-1:0] len);
    @(negedge clk);
    execDone = 1'b1; rspLen = len;
    @(negedge clk);
    seenAvail = evtDataAvail;
    execDone = 1'b0;
  endtask

  task automatic t_reset;
    readSts("R1 reset state", 3'd2, 32'h0000_0084);
    checkEq("R1 no pulses after reset", {29'd0, execStart, evtCmdReady, evtDataAvail}, 32'd0);
  endtask

  task automatic t_foreignRead;
    readSts("R3 other locality read", 3'd0, 32'hFFFF_FFFF);
    locValid = 1'b0;
    readSts("R3 no active locality read", 3'd2, 32'hFFFF_FFFF);
    locValid = 1'b1;
  endtask

  task automatic t_strap;
    selfTestStrap = 1'b0;
    readSts("R11 strap low", 3'd2, 32'h0000_0080);
    selfTestStrap = 1'b1;
    readSts("R11 strap high", 3'd2, 32'h0000_0084);
  endtask

  task automatic t_initIgnores;
    pushBytes(1, 1'b0);
    readSts("R5 fifo byte in Init ignored", 3'd2, 32'h0000_0084);
    regWrite(3'd2, 32'h20);
    readSts("R6 go in Init ignored", 3'd2, 32'h0000_0084);
    checkEq("R6 no start from Init", {31'd0, seenStart}, 32'd0);
  endtask

  task automatic t_filter;
    regWrite(3'd1, 32'h40);
    readSts("R2 wrong locality write", 3'd2, 32'h0000_0084);
    regWrite(3'd2, 32'h60);
    readSts("R2 two-bit write", 3'd2, 32'h0000_0084);
    locValid = 1'b0;
    regWrite(3'd2, 32'h40);
    locValid = 1'b1;
    readSts("R2 write with no active locality", 3'd2, 32'h0000_0084);
  endtask

  task automatic t_cmdReady;
    regWrite(3'd2, 32'h40);
    readSts("R4 Ready status", 3'd2, 32'h0000_40C4);
    checkEq("R4 ready event", {31'd0, seenRdy}, 32'd1);
    regWrite(3'd2, 32'h40);
    checkEq("R4 no event when already Ready", {31'd0, seenRdy}, 32'd0);
  endtask

  task automatic t_earlyControls;
    regWrite(3'd2, 32'h20);
    readSts("R6 go in Ready ignored", 3'd2, 32'h0000_40C4);
    checkEq("R6 no start in Ready", {31'd0, seenStart}, 32'd0);
    regWrite(3'd2, 32'h02);
    readSts("R9 retry in Ready ignored", 3'd2, 32'h0000_40C4);
  endtask

  task automatic t_reception;
    pushBytes(1, 1'b0);
    readSts("R5 first byte enters reception", 3'd2, 32'h0000_408C);
    regWrite(3'd2, 32'h20);
    readSts("R6 go while expect ignored", 3'd2, 32'h0000_408C);
    checkEq("R6 no start while expect", {31'd0, seenStart}, 32'd0);
    pushBytes(99, 1'b0);
    readSts("R10 burst below cap after 100 bytes", 3'd2, 32'h0000_1C8C);
    pushBytes(1, 1'b1);
    readSts("R5 last byte clears expect", 3'd2, 32'h0000_1B84);
    regWrite(3'd2, 32'h60);
    readSts("R2 two-bit write in reception", 3'd2, 32'h0000_1B84);
  endtask

  task automatic t_exec;
    regWrite(3'd2, 32'h20);
    checkEq("R6 go starts execution", {31'd0, seenStart}, 32'd1);
    readSts("R6 execution status", 3'd2, 32'h0000_0004);
    pushBytes(1, 1'b0);
    readSts("R5 fifo byte in execution ignored", 3'd2, 32'h0000_0004);
    finishExec(13'd70);
    checkEq("R7 data available event", {31'd0, seenAvail}, 32'd1);
    readSts("R7 completion status capped", 3'd2, 32'h0000_4094);
  endtask

  task automatic t_response;
    pullBytes(10);
    readSts("R8 ten bytes read", 3'd2, 32'h0000_3C94);
    pushBytes(1, 1'b0);
    readSts("R5 fifo byte in completion ignored", 3'd2, 32'h0000_3C94);
    regWrite(3'd2, 32'h02);
    readSts("R9 retry restores length", 3'd2, 32'h0000_4094);
    pullBytes(70);
    readSts("R8 response drained", 3'd2, 32'h0000_0084);
    pullBytes(1);
    readSts("R8 read past end", 3'd2, 32'h0000_0084);
    finishExec(13'd5);
    checkEq("R7 done outside execution no event", {31'd0, seenAvail}, 32'd0);
    readSts("R7 done outside execution ignored", 3'd2, 32'h0000_0084);
  endtask

  task automatic t_abort;
    regWrite(3'd2, 32'h40);
    checkEq("R4 event from completion", {31'd0, seenRdy}, 32'd1);
    readSts("R4 abort from completion", 3'd2, 32'h0000_40C4);
    pushBytes(130, 1'b0);
    readSts("R10 full fifo burst zero", 3'd2, 32'h0000_008C);
    regWrite(3'd2, 32'h40);
    checkEq("R4 event from reception", {31'd0, seenRdy}, 32'd1);
    readSts("R4 abort from reception", 3'd2, 32'h0000_40C4);
    pushBytes(3, 1'b1);
    regWrite(3'd2, 32'h20);
    finishExec(13'd5);
    readSts("R10 short response uncapped", 3'd2, 32'h0000_0594);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_foreignRead();
    t_strap();
    t_initIgnores();
    t_filter();
    t_cmdReady();
    t_earlyControls();
    t_reception();
    t_exec();
    t_response();
    t_abort();
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule